// File: doc/BRIEF.md
# Parallel Port Host Master

This block lets an embedded processor run an 8-bit parallel peripheral port through a handful of memory-mapped registers. An access to the data or address register becomes one bus cycle on the port. A processor write puts the byte on the port bus, pulls the write line low and pulses the matching active-low strobe. A processor read pulses the same strobe with the write line high. It latches the byte on the port bus when the strobe rises and returns that byte to the processor.

Two shadow registers hand back the last data byte and the last address byte caught from the port, and they create no bus cycle. A status register shows the synchronized interrupt and wait inputs and holds one general-purpose output bit. The peripheral paces each strobed cycle with its wait line. The strobe starts only once wait reads low. It ends when wait rises or when a timeout counter runs out.

The processor bus uses select and ready. The master holds its request until ready is high, then drops or changes the request. Non-strobed registers answer in the same cycle. Strobed registers hold ready low until their port cycle is finished, so only one port cycle runs at a time.

Top module: `ppt_host_port`

## Requirements
- R1: After reset both strobes and the write line are high, the port output enable is low, the general-purpose output is 0 and both shadow registers read 0.
- R2: A write to offset 0x40 (data) pulses the data strobe low once, with the write line low and the written byte driven on the port bus for every strobe-low cycle. The address strobe stays high.
- R3: A write to offset 0x44 (address) pulses the address strobe low once, with the write line low and the written byte driven on the port bus. The data strobe stays high.
- R4: A read of offset 0x40 or 0x44 pulses the matching strobe with the write line high and the output enable low. It returns, with ready, the port byte present when the strobe rises.
- R5: Reads of offset 0x42 and 0x46 return the last byte captured by a data read and by an address read respectively. They assert no strobe and are ready in the cycle they are requested.
- R6: Status offset 0x4E reads as bit 7 = general-purpose output, bit 1 = interrupt input, bit 0 = wait input, bits 6..2 = 0. Each input appears there after a two-flop synchronizer.
- R7: A status write copies data bit 7 to the general-purpose output pin and changes nothing else readable in the status register.
- R8: A strobe asserts only after the synchronized wait input is low. With wait going high k cycles into the strobe, the strobe stays low for exactly k+2 cycles.
- R9: If wait never rises, the strobe is released after exactly TIMEOUT_CYC low cycles and the access still completes.
- R10: During a write cycle the output enable is high from before the strobe falls until after it rises. During a read it is never high.
- R11: Ready stays low while a strobed cycle is in progress and while the strobe is low, and it rises only after the strobe has been released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Processor access request, held until ready |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Register offset (low 8 bits decoded) |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, valid with ready |
| cpu_ready | output | 1 | Access complete |
| pp_data_o | output | 8 | Port bus output byte |
| pp_data_i | input | 8 | Port bus input byte |
| pp_data_oe | output | 1 | Port bus output enable (0 = tri-stated) |
| pp_dstb_n | output | 1 | Active-low data strobe |
| pp_astb_n | output | 1 | Active-low address strobe |
| pp_write_n | output | 1 | Write line, low for write cycles |
| pp_intr | input | 1 | Peripheral interrupt input |
| pp_wait | input | 1 | Peripheral wait/handshake input |
| pp_gpo | output | 1 | General-purpose output |

## Verification
The hardest case to reach is a strobed access that starts while the peripheral still holds wait high. Strobe and ready must then stay quiet until wait falls and passes the synchronizer. The bench raises wait by hand before it issues a write. In a parallel thread it watches the port for several cycles, then drops wait. A peripheral model that raises wait a random number of cycles into each strobe checks the exact strobe length. The same model, switched off, holds wait low so the timeout path runs.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] OFS_DATA = 8'h40;
    localparam logic [7:0] OFS_DBUF = 8'h42;
    localparam logic [7:0] OFS_ADDR = 8'h44;
    localparam logic [7:0] OFS_ABUF = 8'h46;
    localparam logic [7:0] OFS_STAT = 8'h4E;

    typedef enum logic [2:0] {
        REG_DATA,
        REG_ADDR,
        REG_DBUF,
        REG_ABUF,
        REG_STAT,
        REG_NONE
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE,
        ST_DONE
    } cyc_state_e;

    typedef struct packed {
        logic              is_addr;
        logic              is_write;
        logic [BYTE_W-1:0] wbyte;
    } cyc_req_t;

    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            OFS_DATA: return REG_DATA;
            OFS_ADDR: return REG_ADDR;
            OFS_DBUF: return REG_DBUF;
            OFS_ABUF: return REG_ABUF;
            OFS_STAT: return REG_STAT;
            default:  return REG_NONE;
        endcase
    endfunction

    function automatic logic is_strobed(input reg_sel_e r);
        return (r == REG_DATA) || (r == REG_ADDR);
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input logic gpo,
                                                      input logic irq,
                                                      input logic hold);
        return {gpo, 5'b0, irq, hold};
    endfunction

endpackage

// File: rtl/ppt_sync.sv
module ppt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ppt_cycle_seq.sv
module ppt_cycle_seq
    import ppt_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cyc_req_t          req,
    input  logic              wait_s,
    input  logic [BYTE_W-1:0] bus_in,
    output logic              idle,
    output logic              done,
    output logic              cap_valid,
    output logic              cap_is_addr,
    output logic [BYTE_W-1:0] cap_byte,
    output logic              dstb_n,
    output logic              astb_n,
    output logic              write_n,
    output logic              oe,
    output logic [BYTE_W-1:0] dout
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    cyc_state_e       state;
    cyc_req_t         req_q;
    logic [CNT_W-1:0] cnt;
    logic             stb_end;
    logic             in_cyc;
    logic             stb_on;

    assign stb_on  = (state == ST_STROBE);
    assign stb_end = stb_on && (wait_s || (cnt == CNT_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req_q <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q <= req;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (!wait_s) begin
                        cnt   <= '0;
                        state <= ST_STROBE;
                    end
                end
                ST_STROBE: begin
                    if (stb_end) state <= ST_RELEASE;
                    else         cnt   <= cnt + 1'b1;
                end
                ST_RELEASE: state <= ST_DONE;
                ST_DONE:    state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    assign in_cyc      = (state == ST_SETUP) || stb_on || (state == ST_RELEASE);
    assign idle        = (state == ST_IDLE);
    assign done        = (state == ST_DONE);
    assign dstb_n      = !(stb_on && !req_q.is_addr);
    assign astb_n      = !(stb_on &&  req_q.is_addr);
    assign write_n     = !(in_cyc && req_q.is_write);
    assign oe          = in_cyc && req_q.is_write;
    assign dout        = req_q.wbyte;
    assign cap_valid   = stb_end && !req_q.is_write;
    assign cap_is_addr = req_q.is_addr;
    assign cap_byte    = bus_in;
endmodule

// File: rtl/ppt_host_port.sv
module ppt_host_port
    import ppt_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int TIMEOUT_CYC = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_ready,
    output logic [7:0]        pp_data_o,
    input  logic [7:0]        pp_data_i,
    output logic              pp_data_oe,
    output logic              pp_dstb_n,
    output logic              pp_astb_n,
    output logic              pp_write_n,
    input  logic              pp_intr,
    input  logic              pp_wait,
    output logic              pp_gpo
);
    reg_sel_e          rsel;
    logic              strobed;
    logic [1:0]        hs_sync;
    logic              intr_s;
    logic              wait_s;
    logic              seq_idle;
    logic              seq_done;
    logic              cap_valid;
    logic              cap_is_addr;
    logic [BYTE_W-1:0] cap_byte;
    logic [BYTE_W-1:0] dbuf_q;
    logic [BYTE_W-1:0] abuf_q;
    logic              gpo_q;
    cyc_req_t          req;

    assign rsel    = decode_ofs(cpu_addr[7:0]);
    assign strobed = is_strobed(rsel);

    ppt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pp_intr, pp_wait}),
        .q   (hs_sync)
    );
    assign intr_s = hs_sync[1];
    assign wait_s = hs_sync[0];

    assign req.is_addr  = (rsel == REG_ADDR);
    assign req.is_write = cpu_wr;
    assign req.wbyte    = cpu_wdata;

    ppt_cycle_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (cpu_sel && strobed),
        .req         (req),
        .wait_s      (wait_s),
        .bus_in      (pp_data_i),
        .idle        (seq_idle),
        .done        (seq_done),
        .cap_valid   (cap_valid),
        .cap_is_addr (cap_is_addr),
        .cap_byte    (cap_byte),
        .dstb_n      (pp_dstb_n),
        .astb_n      (pp_astb_n),
        .write_n     (pp_write_n),
        .oe          (pp_data_oe),
        .dout        (pp_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dbuf_q <= '0;
            abuf_q <= '0;
            gpo_q  <= 1'b0;
        end else begin
            if (cap_valid) begin
                if (cap_is_addr) abuf_q <= cap_byte;
                else             dbuf_q <= cap_byte;
            end
            if (cpu_sel && cpu_wr && (rsel == REG_STAT) && seq_idle) begin
                gpo_q <= cpu_wdata[7];
            end
        end
    end

    always_comb begin
        case (rsel)
            REG_DATA, REG_DBUF: cpu_rdata = dbuf_q;
            REG_ADDR, REG_ABUF: cpu_rdata = abuf_q;
            REG_STAT:           cpu_rdata = pack_status(gpo_q, intr_s, wait_s);
            default:            cpu_rdata = '0;
        endcase
    end

    assign cpu_ready = cpu_sel && (strobed ? seq_done : seq_idle);
    assign pp_gpo    = gpo_q;
endmodule

// File: rtl/ppt_host_port_chk.sv
module ppt_host_port_chk #(
    parameter int TIMEOUT_CYC = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       pp_dstb_n,
    input logic       pp_astb_n,
    input logic       pp_write_n,
    input logic       pp_data_oe,
    input logic [7:0] pp_data_o,
    input logic       cpu_ready
);
    localparam int CW = $clog2(TIMEOUT_CYC + 2);

    logic          stb_low;
    logic [CW-1:0] low_run;

    assign stb_low = !pp_dstb_n || !pp_astb_n;

    always_ff @(posedge clk) begin
        if (rst)          low_run <= '0;
        else if (stb_low) low_run <= low_run + 1'b1;
        else              low_run <= '0;
    end

    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(!pp_dstb_n && !pp_astb_n));

    // R10
    oe_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_low && !pp_write_n) |-> pp_data_oe);

    // R4
    read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_low && pp_write_n) |-> !pp_data_oe);

    // R11
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stb_low |-> !cpu_ready);

    // R3
    stb_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_low && $past(stb_low)) |-> ($stable(pp_data_o) && $stable(pp_write_n)));

    // R9
    timeout_bound_chk: assert property (@(posedge clk) disable iff (rst)
        low_run <= CW'(TIMEOUT_CYC));

    // R1
    idle_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (pp_write_n) |-> !pp_data_oe);
endmodule

bind ppt_host_port ppt_host_port_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pp_dstb_n  (pp_dstb_n),
    .pp_astb_n  (pp_astb_n),
    .pp_write_n (pp_write_n),
    .pp_data_oe (pp_data_oe),
    .pp_data_o  (pp_data_o),
    .cpu_ready  (cpu_ready)
);

// File: tb/tb_ppt_host_port.sv
module tb_ppt_host_port;
    localparam int CLK_PERIOD = 10;
    localparam int TO         = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_sel = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_addr = 8'h00;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       cpu_ready;
    logic [7:0] pp_data_o;
    logic [7:0] pp_data_i = 8'h00;
    logic       pp_data_oe;
    logic       pp_dstb_n;
    logic       pp_astb_n;
    logic       pp_write_n;
    logic       pp_intr = 1'b0;
    logic       pp_wait = 1'b0;
    logic       pp_gpo;

    int errors = 0;
    int checks = 0;

    bit resp_en    = 1'b1;
    int resp_delay = 1;
    int low_cnt    = 0;

    bit [7:0] exp_dbuf = 8'h00;
    bit [7:0] exp_abuf = 8'h00;
    bit       exp_gpo  = 1'b0;

    logic [7:0] rd;
    int         dlow, alow, cyc;
    bit         bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppt_host_port #(.ADDR_W(8), .TIMEOUT_CYC(TO), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .pp_data_o(pp_data_o), .pp_data_i(pp_data_i),
        .pp_data_oe(pp_data_oe), .pp_dstb_n(pp_dstb_n), .pp_astb_n(pp_astb_n),
        .pp_write_n(pp_write_n), .pp_intr(pp_intr), .pp_wait(pp_wait),
        .pp_gpo(pp_gpo)
    );

    // Peripheral model: raises wait resp_delay cycles into a strobe,
    // lowers it once the strobe has gone high again.
    always @(negedge clk) begin
        if (!rst && resp_en) begin
            if (!pp_dstb_n || !pp_astb_n) begin
                low_cnt = low_cnt + 1;
                if (low_cnt >= resp_delay) pp_wait = 1'b1;
            end else if (low_cnt != 0) begin
                pp_wait = 1'b0;
                low_cnt = 0;
            end
        end
    end

    function automatic bit [7:0] exp_status(bit g, bit i, bit w);
        return {g, 5'b00000, i, w};
    endfunction

    function automatic int exp_low(int delay);
        return (delay + 2 > TO) ? TO : delay + 2;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] ofs, input logic [7:0] wd,
                          output logic [7:0] rdo, output int dl, output int al,
                          output int cy, output bit bd);
        bit prev_stb = 1'b0;
        bit prev_oe  = 1'b0;
        bit sl;
        dl = 0; al = 0; cy = 0; bd = 1'b0; rdo = 8'h00;
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = wr; cpu_addr = ofs; cpu_wdata = wd;
        forever begin
            #1;
            sl = !pp_dstb_n || !pp_astb_n;
            if (!pp_dstb_n) dl++;
            if (!pp_astb_n) al++;
            if (sl && wr && (pp_write_n !== 1'b0 || pp_data_oe !== 1'b1 || pp_data_o !== wd)) bd = 1'b1;
            if (sl && !wr && pp_write_n !== 1'b1) bd = 1'b1;
            if (!wr && pp_data_oe) bd = 1'b1;
            if (wr && sl && !prev_stb && !prev_oe) bd = 1'b1;
            if (wr && !sl && prev_stb && !pp_data_oe) bd = 1'b1;
            if (sl && cpu_ready) bd = 1'b1;
            prev_stb = sl;
            prev_oe  = pp_data_oe;
            if (cpu_ready) begin
                rdo = cpu_rdata;
                break;
            end
            cy++;
            if (cy > 300) begin
                check(1'b0, "R11 access hung", cy, 300);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_abcd));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(pp_dstb_n === 1'b1 && pp_astb_n === 1'b1, "R1 strobes high", {pp_dstb_n, pp_astb_n}, 2'b11);
        check(pp_write_n === 1'b1 && pp_data_oe === 1'b0, "R1 write_n/oe", {pp_write_n, pp_data_oe}, 2'b10);
        check(pp_gpo === 1'b0 && cpu_ready === 1'b0, "R1 gpo/ready", {pp_gpo, cpu_ready}, 0);
        access(1'b0, 8'h42, 8'h00, rd, dlow, alow, cyc, bad);
        check(rd === 8'h00, "R1 data shadow cleared", rd, 0);
        access(1'b0, 8'h46, 8'h00, rd, dlow, alow, cyc, bad);
        check(rd === 8'h00, "R1 address shadow cleared", rd, 0);

        // R8 strobe held off while wait is high
        settle();
        pp_wait = 1'b1;
        low_cnt = 0;
        resp_delay = 1;
        settle();
        fork
            access(1'b1, 8'h40, 8'hA5, rd, dlow, alow, cyc, bad);
            begin
                repeat (8) @(negedge clk);
                #2;
                check(pp_dstb_n === 1'b1 && pp_astb_n === 1'b1, "R8 no strobe while wait high",
                      {pp_dstb_n, pp_astb_n}, 2'b11);
                check(cpu_ready === 1'b0, "R11 ready low while waiting", cpu_ready, 0);
                pp_wait = 1'b0;
            end
        join
        check(dlow == exp_low(1) && alow == 0, "R8 strobe length after wait release", dlow, exp_low(1));
        check(!bad, "R2 write cycle pins", bad, 0);

        // R9 timeout with wait stuck low
        settle();
        resp_en = 1'b0;
        pp_wait = 1'b0;
        pp_data_i = 8'h3C;
        access(1'b0, 8'h44, 8'h00, rd, dlow, alow, cyc, bad);
        check(alow == TO && dlow == 0, "R9 timeout strobe length", alow, TO);
        check(rd === 8'h3C && !bad, "R9 read completes on timeout", rd, 8'h3C);
        exp_abuf = 8'h3C;
        resp_en = 1'b1;
        low_cnt = 0;

        // R7 status write changes only bit 7
        settle();
        pp_intr = 1'b1;
        access(1'b1, 8'h4E, 8'h7F, rd, dlow, alow, cyc, bad);
        check(pp_gpo === 1'b0 && dlow == 0 && alow == 0, "R7 bit7 clear ignores low bits", pp_gpo, 0);
        access(1'b1, 8'h4E, 8'h80, rd, dlow, alow, cyc, bad);
        exp_gpo = 1'b1;
        check(pp_gpo === 1'b1, "R7 gpo set from bit7", pp_gpo, 1);
        settle();
        access(1'b0, 8'h4E, 8'h00, rd, dlow, alow, cyc, bad);
        check(rd === exp_status(1'b1, 1'b1, pp_wait), "R6 status layout", rd, exp_status(1'b1, 1'b1, pp_wait));

        // Random mix
        for (int n = 0; n < 80; n++) begin
            int op = $urandom_range(0, 6);
            logic [7:0] b = 8'($urandom);
            resp_delay = $urandom_range(1, 6);
            settle();
            case (op)
                0: begin
                    access(1'b1, 8'h40, b, rd, dlow, alow, cyc, bad);
                    check(dlow == exp_low(resp_delay) && alow == 0 && !bad, "R2 data write",
                          dlow, exp_low(resp_delay));
                    check(!bad, "R10 oe framing on data write", bad, 0);
                end
                1: begin
                    access(1'b1, 8'h44, b, rd, dlow, alow, cyc, bad);
                    check(alow == exp_low(resp_delay) && dlow == 0 && !bad, "R3 address write",
                          alow, exp_low(resp_delay));
                end
                2: begin
                    pp_data_i = b;
                    access(1'b0, 8'h40, 8'h00, rd, dlow, alow, cyc, bad);
                    exp_dbuf = b;
                    check(rd === b && dlow == exp_low(resp_delay) && alow == 0 && !bad,
                          "R4 data read", rd, b);
                end
                3: begin
                    pp_data_i = b;
                    access(1'b0, 8'h44, 8'h00, rd, dlow, alow, cyc, bad);
                    exp_abuf = b;
                    check(rd === b && alow == exp_low(resp_delay) && dlow == 0 && !bad,
                          "R4 address read", rd, b);
                end
                4: begin
                    pp_data_i = ~b;
                    access(1'b0, ($urandom_range(0, 1) != 0) ? 8'h42 : 8'h46, 8'h00, rd, dlow, alow, cyc, bad);
                    check((cpu_addr == 8'h42 ? rd === exp_dbuf : rd === exp_abuf)
                          && dlow == 0 && alow == 0 && cyc == 0,
                          "R5 shadow read", rd, cpu_addr == 8'h42 ? exp_dbuf : exp_abuf);
                end
                5: begin
                    access(1'b1, 8'h4E, b, rd, dlow, alow, cyc, bad);
                    exp_gpo = b[7];
                    check(pp_gpo === exp_gpo && dlow == 0 && alow == 0, "R7 status write", pp_gpo, exp_gpo);
                end
                default: begin
                    pp_intr = b[0];
                    settle();
                    access(1'b0, 8'h4E, 8'h00, rd, dlow, alow, cyc, bad);
                    check(rd === exp_status(exp_gpo, b[0], pp_wait), "R6 status read",
                          rd, exp_status(exp_gpo, b[0], pp_wait));
                end
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule